// File: doc/BRIEF.md
# Burst Read Sequencer

This block turns a single read request into the command traffic of a synchronous DRAM-style device and hands four 64-bit words back to the requester. A request carries a start word address. The block splits the address into a row part and a column part. It opens the row with an activate command and fetches data with a read command. In every other cycle it drives the no-operation code. It strobes each returned word to the requester in the cycle the memory presents it.

Timing follows a lead/beat pattern. The first word arrives `lead` cycles after the activate cycle starts, and each further word arrives `beat` cycles after the one before it. The default pattern is 6-1-1-1, which moves four words in 9 cycles. A run-time mode input selects burst operation or non-burst operation. In non-burst mode every word repeats the whole activate, read and data sequence, so 6-6-6-6 takes 24 cycles. The timing inputs and the mode are sampled once, when a request is accepted, and hold for the whole transfer.

Top module: `burst_read_seq`

## Requirements
- R1: When `req` is high and the block is idle, `ack` is high in that same cycle, and the next cycle is the activate cycle (cycle 0). `busy` is high from cycle 0 through the cycle of the fourth word. While `busy` is high, `req` is ignored and `ack` stays low.
- R2: The command codes are no-operation = 2'b00, activate = 2'b01 and read = 2'b10. Whenever no activate or read is issued, including while idle, `cmd` is 2'b00 and `mem_addr` is zero.
- R3: With an address of ROW_W+COL_W bits, the row is the upper ROW_W bits and the column is the lower COL_W bits. The activate command carries the row on `mem_addr`, and a read command carries a column on `mem_addr`, zero-extended.
- R4: In burst mode (`burst_en`=1) each request issues exactly one activate, in cycle 0, and exactly one read, in cycle 3, which carries the start column. No further read is issued until all four words have been delivered.
- R5: In burst mode word j (j = 0..3) is delivered in cycle lead-1+j*beat, with `rd_valid` high and `rd_data` equal to `mem_rdata`. The transfer lasts lead+3*beat cycles (9 for 6-1-1-1). Outside those cycles `rd_valid` is low and `rd_data` is zero.
- R6: In non-burst mode (`burst_en`=0) word w (w = 0..3) has an activate with the row in cycle w*lead, a read with column w in cycle w*lead+3, and delivery in cycle w*lead+lead-1. The transfer lasts 4*lead cycles (24 for 6-6-6-6).
- R7: The column of word j keeps the upper COL_W-2 bits of the start column. Its lower 2 bits are the start column's lower 2 bits plus j, modulo 4, so the column wraps inside its aligned group of four.
- R8: `lead_cyc`, `beat_cyc`, `burst_en` and `req_addr` are sampled only at acceptance. Changing them while `busy` is high does not change the running transfer.
- R9: A `lead_cyc` value below 5 is treated as 5, and a `beat_cyc` value of 0 is treated as 1. Otherwise lead ranges up to 15 and beat ranges from 1 to 3.
- R10: If `rst_n` is low at a rising clock edge, then after that edge `busy` is low, `cmd` is no-operation and `rd_valid` is low, even when a transfer was in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Read request |
| req_addr | input | ROW_W+COL_W | Start word address |
| burst_en | input | 1 | 1 = burst timing, 0 = full sequence for every word |
| lead_cyc | input | XW | Cycles to the first word (lead) |
| beat_cyc | input | YW | Cycles per later word in burst mode (beat) |
| ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Transfer in progress |
| cmd | output | 2 | Command code to memory |
| mem_addr | output | max(ROW_W,COL_W) | Row or column carried with the command |
| mem_rdata | input | DATA_W | Data word from memory |
| rd_valid | output | 1 | Word strobe to requester |
| rd_data | output | DATA_W | Word to requester |

## Verification
The bench builds the block with its defaults: a 13-bit row, a 10-bit column, 64-bit data, a 4-bit lead field and a 2-bit beat field. With a 10-bit column every start offset inside a group of four can be placed, so every wrap of the per-word column is within reach. With a 4-bit lead field the bench can apply values below the floor of 5 as well as 6 and 7, and with a 2-bit beat field it can apply every beat value, including the zero that is clamped. A behavioural memory watches the command bus and returns row- and column-tagged words after a latency set by the bench. The bench checks every cycle of each transfer against a schedule computed from the requirements, for 6-1-1-1, 6-2-2-2, 6-3-3-3, 6-6-6-6 and the clamped and mid-transfer-change cases.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
// bseq_pkg: shared types and constants of the burst read sequencer.
// Assumes a transfer is always four words and the read follows the
// activate by a fixed three cycles.
package bseq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_ACT = 2'b01,
        CMD_RD  = 2'b10
    } cmd_e;

    localparam int BEATS     = 4;
    localparam int BEAT_W    = $clog2(BEATS);
    localparam int RD_OFFSET = 3;
    localparam int MIN_LEAD  = RD_OFFSET + 2;

endpackage

// File: rtl/bseq_cfg_latch.sv
`timescale 1ns/1ps
// bseq_cfg_latch: samples the request address, mode and timing when a
// request is accepted, clamps the timing to legal values and holds all
// of it for the rest of the transfer.
// Assumes accept is high for exactly one cycle per transfer.
module bseq_cfg_latch
    import bseq_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int XW    = 4,
    parameter int YW    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic                   burst_en,
    input  logic [XW-1:0]          lead_cyc,
    input  logic [YW-1:0]          beat_cyc,
    output logic [ROW_W-1:0]       row_q,
    output logic [COL_W-1:0]       col_q,
    output logic                   burst_q,
    output logic [XW-1:0]          x_q,
    output logic [YW-1:0]          y_q
);

    localparam logic [XW-1:0] LEAD_FLOOR = XW'(MIN_LEAD);
    localparam logic [YW-1:0] BEAT_FLOOR = YW'(1);

    logic [XW-1:0] x_eff;
    logic [YW-1:0] y_eff;

    // Clamp requested timing into the supported range.
    always_comb begin
        x_eff = (lead_cyc < LEAD_FLOOR) ? LEAD_FLOOR : lead_cyc;
        y_eff = (beat_cyc == '0) ? BEAT_FLOOR : beat_cyc;
    end

    // Capture request fields on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            burst_q <= 1'b0;
            x_q     <= LEAD_FLOOR;
            y_q     <= BEAT_FLOOR;
        end else if (accept) begin
            row_q   <= req_addr[ROW_W+COL_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            burst_q <= burst_en;
            x_q     <= x_eff;
            y_q     <= y_eff;
        end
    end

    AST_LEAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (x_q >= LEAD_FLOOR) && (y_q != '0)); // R9
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(x_q) && $stable(y_q) && $stable(burst_q) && $stable(col_q)); // R8

endmodule

// File: rtl/bseq_timer.sv
`timescale 1ns/1ps
// bseq_timer: cycle sequencer. A LEAD phase counts 1..lead and places
// the activate at count 1, the read at count 4 and a word at count lead.
// In burst mode the TAIL phase then spaces the later words beat cycles
// apart. In non-burst mode LEAD repeats once for every word.
// Assumes x_q >= 5 and y_q >= 1 (ensured by bseq_cfg_latch).
module bseq_timer
    import bseq_pkg::*;
#(
    parameter int XW = 4,
    parameter int YW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              burst_q,
    input  logic [XW-1:0]     x_q,
    input  logic [YW-1:0]     y_q,
    output logic              ack,
    output logic              busy,
    output logic              act_now,
    output logic              rd_now,
    output logic              beat_now,
    output logic [BEAT_W-1:0] beat_idx
);

    localparam logic [XW-1:0]     LEAD_ONE  = XW'(1);
    localparam logic [XW-1:0]     RD_SLOT   = XW'(RD_OFFSET + 1);
    localparam logic [YW-1:0]     GAP_ONE   = YW'(1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef enum logic [1:0] {S_IDLE, S_LEAD, S_TAIL} phase_e;

    phase_e            st;
    logic [XW-1:0]     tcnt;
    logic [YW-1:0]     gap;
    logic [BEAT_W-1:0] beat;
    logic              lead_end;
    logic              tail_end;

    // Decode the per-cycle events from the phase counters.
    always_comb begin
        lead_end = (st == S_LEAD) && (tcnt == x_q);
        tail_end = (st == S_TAIL) && (gap == y_q);
        ack      = req && (st == S_IDLE);
        busy     = (st != S_IDLE);
        act_now  = (st == S_LEAD) && (tcnt == LEAD_ONE);
        rd_now   = (st == S_LEAD) && (tcnt == RD_SLOT);
        beat_now = lead_end || tail_end;
        beat_idx = beat;
    end

    // Advance phase, lead counter, gap counter and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            tcnt <= '0;
            gap  <= '0;
            beat <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req) begin
                        st   <= S_LEAD;
                        tcnt <= LEAD_ONE;
                        beat <= '0;
                    end
                end
                S_LEAD: begin
                    if (!lead_end) begin
                        tcnt <= tcnt + LEAD_ONE;
                    end else if (beat == LAST_BEAT) begin
                        st <= S_IDLE;
                    end else begin
                        beat <= beat + 1'b1;
                        if (burst_q) begin
                            st  <= S_TAIL;
                            gap <= GAP_ONE;
                        end else begin
                            tcnt <= LEAD_ONE;
                        end
                    end
                end
                S_TAIL: begin
                    if (!tail_end) begin
                        gap <= gap + GAP_ONE;
                    end else if (beat == LAST_BEAT) begin
                        st <= S_IDLE;
                    end else begin
                        beat <= beat + 1'b1;
                        gap  <= GAP_ONE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_LAST_WORD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_now && beat_idx == LAST_BEAT) |=> !busy); // R5
    AST_BURST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && burst_q) |-> (beat_idx == '0)); // R4
    AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> act_now && busy); // R1

endmodule

// File: rtl/bseq_cmd_out.sv
`timescale 1ns/1ps
// bseq_cmd_out: drives the command bus and the requester data port.
// It places the row on activate and the wrapped column of the current
// word on read, and passes memory data through only in word cycles.
// Assumes at most one of act_now and rd_now is high in any cycle.
module bseq_cmd_out
    import bseq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int MA_W   = 13,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_now,
    input  logic              rd_now,
    input  logic              beat_now,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [COL_W-1:0]  col_q,
    input  logic [DATA_W-1:0] mem_rdata,
    output cmd_e              cmd_r,
    output logic [MA_W-1:0]   mem_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [COL_W-1:0]  col_at;
    logic [BEAT_W-1:0] col_low;

    // Column of the current word, wrapping inside its aligned group.
    always_comb begin
        col_low = col_q[BEAT_W-1:0] + beat_idx;
        col_at  = {col_q[COL_W-1:BEAT_W], col_low};
    end

    // Select command and address; zero address with no-operation.
    always_comb begin
        cmd_r    = CMD_NOP;
        mem_addr = '0;
        if (act_now) begin
            cmd_r    = CMD_ACT;
            mem_addr = MA_W'(row_q);
        end else if (rd_now) begin
            cmd_r    = CMD_RD;
            mem_addr = MA_W'(col_at);
        end
    end

    // Gate memory data onto the requester port in word cycles only.
    always_comb begin
        rd_valid = beat_now;
        rd_data  = beat_now ? mem_rdata : '0;
    end

    AST_NOP_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_r == CMD_NOP) |-> (mem_addr == '0)); // R2
    AST_READ_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_r == CMD_RD) |-> ($past(cmd_r, 3) == CMD_ACT)); // R4

endmodule

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
// burst_read_seq: top of the burst read sequencer. One accepted request
// produces an activate/read command sequence and four 64-bit words
// strobed to the requester, in burst or non-burst timing.
// Assumes the memory presents each word on mem_rdata in its word cycle.
module burst_read_seq
    import bseq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int DATA_W = 64,
    parameter int XW     = 4,
    parameter int YW     = 2,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              burst_en,
    input  logic [XW-1:0]     lead_cyc,
    input  logic [YW-1:0]     beat_cyc,
    output logic              ack,
    output logic              busy,
    output logic [1:0]        cmd,
    output logic [MA_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              burst_q;
    logic [XW-1:0]     x_q;
    logic [YW-1:0]     y_q;
    logic              act_now;
    logic              rd_now;
    logic              beat_now;
    logic [BEAT_W-1:0] beat_idx;
    cmd_e              cmd_r;

    bseq_cfg_latch #(.ROW_W(ROW_W), .COL_W(COL_W), .XW(XW), .YW(YW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .accept(ack), .req_addr(req_addr),
        .burst_en(burst_en), .lead_cyc(lead_cyc), .beat_cyc(beat_cyc),
        .row_q(row_q), .col_q(col_q), .burst_q(burst_q), .x_q(x_q), .y_q(y_q)
    );

    bseq_timer #(.XW(XW), .YW(YW)) u_timer (
        .clk(clk), .rst_n(rst_n), .req(req), .burst_q(burst_q), .x_q(x_q),
        .y_q(y_q), .ack(ack), .busy(busy), .act_now(act_now), .rd_now(rd_now),
        .beat_now(beat_now), .beat_idx(beat_idx)
    );

    bseq_cmd_out #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .act_now(act_now), .rd_now(rd_now),
        .beat_now(beat_now), .beat_idx(beat_idx), .row_q(row_q), .col_q(col_q),
        .mem_rdata(mem_rdata), .cmd_r(cmd_r), .mem_addr(mem_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Present the command enum on the plain port.
    assign cmd = cmd_r;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cmd == 2'b00) && !rd_valid); // R2
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack); // R1
    AST_START_WITH_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (cmd == 2'b01)); // R1
    AST_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(burst_q) && $stable(row_q)); // R8

endmodule

// File: tb/tb_burst_read_seq.sv
`timescale 1ns/1ps
// tb_burst_read_seq: walks a table of transfers against a behavioural
// memory, then runs directed reset cases.
module tb_burst_read_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [22:0] req_addr = '0;
    logic        burst_en = 1'b1;
    logic [3:0]  lead_cyc = 4'd6;
    logic [1:0]  beat_cyc = 2'd1;
    logic        ack, busy, rd_valid;
    logic [1:0]  cmd;
    logic [12:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic [63:0] rd_data;

    int checks = 0;
    int fails  = 0;

    burst_read_seq dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .burst_en(burst_en), .lead_cyc(lead_cyc), .beat_cyc(beat_cyc),
        .ack(ack), .busy(busy), .cmd(cmd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    function automatic logic [63:0] word_of(input logic [12:0] row, input logic [9:0] col);
        return {16'hC0DE, 3'b000, row, 22'h0, col};
    endfunction

    function automatic logic [9:0] wrap_col(input logic [9:0] col, input int j);
        logic [1:0] lo;
        lo = col[1:0] + 2'(j);
        return {col[9:2], lo};
    endfunction

    // Behavioural memory: after a read it presents a word every mm_y
    // cycles, the first one mm_lat cycles after the read.
    int          mm_lat = 2;
    int          mm_y   = 1;
    int          mm_cnt = -1;
    logic [12:0] mm_row = '0;
    logic [9:0]  mm_col = '0;
    always @(negedge clk) begin
        int rel;
        if (!rst_n) mm_cnt = -1;
        else if (cmd == 2'b01) mm_row = mem_addr;
        else if (cmd == 2'b10) begin mm_col = mem_addr[9:0]; mm_cnt = 0; end
        else if (mm_cnt >= 0) mm_cnt++;
        rel = mm_cnt + 1;
        if (mm_cnt >= 0 && rel >= mm_lat && ((rel - mm_lat) % mm_y) == 0
            && ((rel - mm_lat) / mm_y) < 4)
            mem_rdata = word_of(mm_row, wrap_col(mm_col, (rel - mm_lat) / mm_y));
        else
            mem_rdata = 64'hBAD0_BAD0_BAD0_BAD0;
    end

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Table: {burst, lead[3:0], beat[1:0], addr[22:0], cycles[7:0], scramble}
    localparam int NV = 7;
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 4'd6, 2'd1, {13'h0123, 10'h040}, 8'd9,  1'b0},
        {1'b1, 4'd6, 2'd2, {13'h1ABC, 10'h2F2}, 8'd12, 1'b0},
        {1'b1, 4'd6, 2'd3, {13'h0005, 10'h3FF}, 8'd15, 1'b0},
        {1'b0, 4'd6, 2'd1, {13'h0777, 10'h105}, 8'd24, 1'b0},
        {1'b1, 4'd3, 2'd0, {13'h1001, 10'h00B}, 8'd8,  1'b0},
        {1'b1, 4'd7, 2'd2, {13'h0F0F, 10'h1C1}, 8'd13, 1'b1},
        {1'b0, 4'd5, 2'd3, {13'h0042, 10'h0A7}, 8'd20, 1'b1}
    };

    // One transfer, checked every cycle against the requirement schedule.
    task automatic run_case(input logic b, input logic [3:0] xi, input logic [1:0] yi,
                            input logic [22:0] a, input int tot, input logic scr, input string tag);
        int xe, ye, e_tot, busy_n, val_n;
        logic [12:0] row;
        logic [9:0]  col;
        xe = (xi < 5) ? 5 : int'(xi);
        ye = (yi == 0) ? 1 : int'(yi);
        e_tot = b ? xe + 3 * ye : 4 * xe;
        mm_lat = xe - 4;
        mm_y = ye;
        row = a[22:10];
        col = a[9:0];
        busy_n = 0;
        val_n = 0;
        @(negedge clk);
        req = 1'b1; req_addr = a; burst_en = b; lead_cyc = xi; beat_cyc = yi;
        #1 chk(ack === 1'b1, {tag, " R1 ack on accept"}, 128'(ack), 128'(1));
        @(posedge clk); #1;
        if (scr) begin
            burst_en = ~b; lead_cyc = 4'd15; beat_cyc = 2'd3; req_addr = ~a;
        end else req = 1'b0;
        for (int k = 0; k <= e_tot; k++) begin
            logic [1:0]  e_cmd;
            logic [12:0] e_addr;
            logic        e_v;
            logic [63:0] e_d;
            if (k > 0) begin @(posedge clk); #1; end
            if (k == 2) req = 1'b0;
            e_cmd = 2'b00; e_addr = '0; e_v = 1'b0; e_d = '0;
            if (b) begin
                if (k == 0) begin e_cmd = 2'b01; e_addr = row; end
                if (k == 3) begin e_cmd = 2'b10; e_addr = 13'(col); end
                if (k >= xe - 1 && ((k - xe + 1) % ye) == 0 && ((k - xe + 1) / ye) < 4) begin
                    e_v = 1'b1; e_d = word_of(row, wrap_col(col, (k - xe + 1) / ye));
                end
            end else if (k / xe < 4) begin
                if (k % xe == 0) begin e_cmd = 2'b01; e_addr = row; end
                if (k % xe == 3) begin e_cmd = 2'b10; e_addr = 13'(wrap_col(col, k / xe)); end
                if (k % xe == xe - 1) begin e_v = 1'b1; e_d = word_of(row, wrap_col(col, k / xe)); end
            end
            chk({cmd, mem_addr} === {e_cmd, e_addr},
                $sformatf("%s R2 R3 R4 R6 R7 cmd/addr cycle %0d", tag, k),
                128'({cmd, mem_addr}), 128'({e_cmd, e_addr}));
            chk({rd_valid, rd_data} === {e_v, e_d},
                $sformatf("%s R5 R6 R7 word cycle %0d", tag, k),
                128'({rd_valid, rd_data}), 128'({e_v, e_d}));
            chk(busy === (k < e_tot), $sformatf("%s R1 busy cycle %0d", tag, k),
                128'(busy), 128'(k < e_tot));
            chk(ack === 1'b0, $sformatf("%s R1 no ack while busy cycle %0d", tag, k),
                128'(ack), 128'(0));
            busy_n += int'(busy);
            val_n += int'(rd_valid);
        end
        req = 1'b0;
        chk(busy_n == tot, {tag, " R5 R6 total cycles"}, 128'(busy_n), 128'(tot));
        chk(val_n == 4, {tag, " R5 R6 word count"}, 128'(val_n), 128'(4));
    endtask

    initial begin
        #(4 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 R2: state after reset
        chk({busy, cmd, mem_addr, rd_valid, ack} === '0, "R10 R2 reset state",
            128'({busy, cmd, mem_addr, rd_valid, ack}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk({busy, cmd, mem_addr} === '0, "R2 idle drives nop",
            128'({busy, cmd, mem_addr}), 128'(0));

        for (int i = 0; i < NV; i++) begin
            logic [38:0] v;
            v = VEC[i];
            run_case(v[38], v[37:34], v[33:32], v[31:9], int'(v[8:1]), v[0],
                     $sformatf("vec%0d%s%s", i, v[0] ? " R8" : "",
                               (v[37:34] < 4'd5) ? " R9" : ""));
        end

        // R10: reset in the middle of a transfer
        @(negedge clk);
        req = 1'b1; req_addr = {13'h0033, 10'h011}; burst_en = 1'b1;
        lead_cyc = 4'd6; beat_cyc = 2'd1;
        @(posedge clk); #1;
        req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk({busy, cmd, rd_valid} === '0, "R10 mid-transfer reset",
            128'({busy, cmd, rd_valid}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk({busy, cmd, mem_addr, rd_valid} === '0, "R10 R2 quiet after reset release",
            128'({busy, cmd, mem_addr, rd_valid}), 128'(0));

        // Recovery: default pattern again after the reset
        run_case(1'b1, 4'd6, 2'd1, {13'h1FFF, 10'h3FE}, 9, 1'b0, "post-reset R4 R5 R7");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule